// File: doc/BRIEF.md
# All-to-All Spike Broadcast Router

This block is the central routing core of a star-shaped spike interconnect. Up to twelve node-facing ports each present at most one spike label per clock cycle. A spike that arrives on a source port is copied to every destination port whose bit is set in a static source-by-destination enable matrix. A destination is not excluded for being the source itself. Each destination serves one spike per cycle, so that a sustained single-source stream passes at full rate at the 250 MHz user clock.

Several sources may target the same destination in one cycle. Each destination therefore keeps a separate queue for every source and picks between the non-empty queues with a round-robin arbiter. A destination can be paused for a cycle, for example while its transceiver inserts clock-compensation symbols. Its queues then hold their contents. When a queue is full, further spikes for it are discarded and that destination's drop counter advances. The enable matrix is written one source row at a time through a small configuration port.

Top module: `spike_router`

## Requirements
- R1: After reset every out_valid bit is 0, every drop counter is 0 and every enable bit is 0, so a spike sent before configuration reaches no output.
- R2: A spike sampled from source s at clock edge E appears at edge E+1 on every destination d with enable bit [s][d] set. The outputs carry the unchanged label and out_src equal to s, provided the destination is unpaused and has no other queued work.
- R3: A destination whose enable bit for source s is clear, including d equal to s, never emits a spike from s.
- R4: A write with cfg_we high sets enable bits [cfg_row][d] to cfg_mask[d] at the sampling edge. A spike sampled at that same edge uses the previous row, and a spike sampled at any later edge uses the new row.
- R5: The spikes from one source to one destination leave in the order in which they arrived.
- R6: When several source queues of one destination hold spikes, the grant goes to the first non-empty source after the previously granted one, counting upward with wrap-around. Before the first grant the previous source is taken to be the highest index, so source 0 is served first.
- R7: If pause[d] is high at an edge, out_valid[d] is 0 in the following cycle. Queued spikes are kept and delivered once pause falls.
- R8: A destination fed by a single source on every cycle emits one spike per cycle without a gap.
- R9: Each queue holds 16 spikes. A spike that arrives for a full queue is dropped, and the destination's drop counter (field d of ovf_count, bits d*16 upward) rises by one for each such spike. The counter never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 12 | Spike present on source port s (bit s) |
| in_label | input | 96 | Spike label per source, 8 bits each, port s at bits s*8 upward |
| pause | input | 12 | Hold output of destination d this cycle |
| cfg_we | input | 1 | Write one row of the enable matrix |
| cfg_row | input | 4 | Source index of the row written |
| cfg_mask | input | 12 | New destination enables of that row |
| out_valid | output | 12 | Spike present on destination d |
| out_label | output | 96 | Label per destination, 8 bits each |
| out_src | output | 48 | Source index per destination, 4 bits each |
| ovf_count | output | 192 | Drop counter per destination, 16 bits each |

## Verification
The bench first sends a single spike to a mixed destination row, including the source's own position. This shows that copies go only to enabled ports and that each arrives exactly one edge later. It then drives three sources into one destination on consecutive cycles, which tests the round-robin order against per-source FIFO order. A long single-source stream tests for gaps in the output. A configuration write placed in the same cycle as a spike shows which matrix each spike sees. Finally, a burst into a paused destination is sent until its queue fills. This separates holding from losing spikes and counts exactly the spikes that are dropped.

// File: rtl/spike_router_pkg.sv
package spike_router_pkg;
    localparam int DEF_PORTS = 12;
    localparam int DEF_LBL_W = 8;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_CNT_W = 16;
endpackage

// File: rtl/srt_fifo.sv
module srt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= din;
    end
endmodule

// File: rtl/srt_rr_arb.sv
module srt_rr_arb #(
    parameter int N  = 12,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [SW-1:0] gnt_idx,
    output logic          gnt_any
);
    typedef struct packed {
        logic [SW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(st_q.last) + k;
            if (c >= N) c = c - N;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = SW'(c);
            end
        end
        st_d = st_q;
        if (adv && gnt_any) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.last <= SW'(N - 1);
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srt_dest_port.sv
module srt_dest_port #(
    parameter int N     = 12,
    parameter int LW    = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int SW    = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    push,
    input  logic [N*LW-1:0] lbl_in,
    input  logic            pause,
    output logic            out_valid,
    output logic [LW-1:0]   out_label,
    output logic [SW-1:0]   out_src,
    output logic [CNT_W-1:0] ovf_cnt
);
    localparam int DW = $clog2(N + 1);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        logic            valid;
        logic [LW-1:0]   label;
        logic [SW-1:0]   src;
        logic [CNT_W-1:0] ovf;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [N-1:0]  q_empty, q_full, q_pop;
    logic [LW-1:0] q_dout [N];
    logic [SW-1:0] gnt_idx;
    logic          gnt_any, pop_any;

    for (genvar s = 0; s < N; s++) begin : g_srcq
        srt_fifo #(.W(LW), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[s]),
            .din   (lbl_in[s*LW +: LW]),
            .pop   (q_pop[s]),
            .dout  (q_dout[s]),
            .empty (q_empty[s]),
            .full  (q_full[s])
        );
    end

    srt_rr_arb #(.N(N), .SW(SW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (~q_empty),
        .adv     (pop_any),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign pop_any = gnt_any && !pause;

    always_comb begin
        logic [DW-1:0]  drops;
        logic [CNT_W:0] sum;
        q_pop = '0;
        for (int s = 0; s < N; s++) begin
            if (pop_any && (gnt_idx == SW'(s))) q_pop[s] = 1'b1;
        end
        st_d       = st_q;
        st_d.valid = pop_any;
        if (pop_any) begin
            st_d.label = q_dout[gnt_idx];
            st_d.src   = gnt_idx;
        end
        drops = DW'($countones(push & q_full));
        sum   = {1'b0, st_q.ovf} + (CNT_W + 1)'(drops);
        st_d.ovf = (sum > CNT_MAX) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_label = st_q.label;
    assign out_src   = st_q.src;
    assign ovf_cnt   = st_q.ovf;
endmodule

// File: rtl/spike_router.sv
module spike_router
    import spike_router_pkg::*;
#(
    parameter int NPORTS     = DEF_PORTS,
    parameter int LBL_W      = DEF_LBL_W,
    parameter int FIFO_DEPTH = DEF_DEPTH,
    parameter int CNT_W      = DEF_CNT_W,
    localparam int SRC_W     = $clog2(NPORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS-1:0]       in_valid,
    input  logic [NPORTS*LBL_W-1:0] in_label,
    input  logic [NPORTS-1:0]       pause,
    input  logic                    cfg_we,
    input  logic [SRC_W-1:0]        cfg_row,
    input  logic [NPORTS-1:0]       cfg_mask,
    output logic [NPORTS-1:0]       out_valid,
    output logic [NPORTS*LBL_W-1:0] out_label,
    output logic [NPORTS*SRC_W-1:0] out_src,
    output logic [NPORTS*CNT_W-1:0] ovf_count
);
    typedef struct packed {
        logic [NPORTS-1:0][NPORTS-1:0] en;
    } route_st_t;

    route_st_t st_d, st_q;
    logic [NPORTS*NPORTS-1:0] en_flat;
    logic [NPORTS-1:0] dst_push [NPORTS];

    assign en_flat = st_q.en;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_row) < NPORTS)) st_d.en[cfg_row] = cfg_mask;
        for (int d = 0; d < NPORTS; d++) begin
            for (int s = 0; s < NPORTS; s++) begin
                dst_push[d][s] = in_valid[s] && st_q.en[s][d];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar d = 0; d < NPORTS; d++) begin : g_dst
        srt_dest_port #(
            .N     (NPORTS),
            .LW    (LBL_W),
            .DEPTH (FIFO_DEPTH),
            .CNT_W (CNT_W),
            .SW    (SRC_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (dst_push[d]),
            .lbl_in    (in_label),
            .pause     (pause[d]),
            .out_valid (out_valid[d]),
            .out_label (out_label[d*LBL_W +: LBL_W]),
            .out_src   (out_src[d*SRC_W +: SRC_W]),
            .ovf_cnt   (ovf_count[d*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/spike_router_chk.sv
module spike_router_chk #(
    parameter int N     = 12,
    parameter int CNT_W = 16,
    parameter int SW    = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     pause,
    input logic [N-1:0]     out_valid,
    input logic             cfg_we,
    input logic [SW-1:0]    cfg_row,
    input logic [N-1:0]     cfg_mask,
    input logic [N*N-1:0]   en_flat,
    input logic [N*CNT_W-1:0] ovf_count
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pause) |=> ((out_valid & $past(pause)) == '0));

    // R4
    cfg_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_row) < N)) |=> (en_flat[$past(cfg_row)*N +: N] == $past(cfg_mask)));

    for (genvar p = 0; p < N; p++) begin : g_cnt
        // R9
        ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_count[p*CNT_W +: CNT_W] >= $past(ovf_count[p*CNT_W +: CNT_W]));
    end
endmodule

bind spike_router spike_router_chk #(.N(NPORTS), .CNT_W(CNT_W), .SW(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause     (pause),
    .out_valid (out_valid),
    .cfg_we    (cfg_we),
    .cfg_row   (cfg_row),
    .cfg_mask  (cfg_mask),
    .en_flat   (en_flat),
    .ovf_count (ovf_count)
);

// File: tb/spike_router_bench.sv
module spike_router_bench;
    localparam int N  = 12;
    localparam int W  = 8;
    localparam int DP = 16;
    localparam int CW = 16;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*W-1:0]  in_label = '0;
    logic [N-1:0]    pause = '0;
    logic            cfg_we = 1'b0;
    logic [SW-1:0]   cfg_row = '0;
    logic [N-1:0]    cfg_mask = '0;
    logic [N-1:0]    out_valid;
    logic [N*W-1:0]  out_label;
    logic [N*SW-1:0] out_src;
    logic [N*CW-1:0] ovf_count;

    always #10 clk = ~clk;

    spike_router u_spike_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_label(in_label),
        .pause(pause), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_mask(cfg_mask),
        .out_valid(out_valid), .out_label(out_label), .out_src(out_src),
        .ovf_count(ovf_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int first9 = -1;
    int last9 = -1;
    int out_cnt [N];
    int drop_exp [N];
    int order7 [$];
    logic [N-1:0] men [N];
    logic [W-1:0] expq [N*N][$];
    logic [W-1:0] seq = 8'd1;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic [N-1:0] v, input logic we, input int row, input logic [N-1:0] mask);
        @(negedge clk);
        in_valid = v;
        for (int s = 0; s < N; s++) begin
            in_label[s*W +: W] = seq;
            if (v[s]) begin
                for (int d = 0; d < N; d++) begin
                    if (men[s][d]) begin
                        if (expq[d*N+s].size() >= DP) drop_exp[d]++;
                        else expq[d*N+s].push_back(seq);
                    end
                end
            end
            seq = seq + 8'd1;
        end
        cfg_we   = we;
        cfg_row  = SW'(row);
        cfg_mask = mask;
        if (we) men[row] = mask;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick('0, 1'b0, 0, '0);
    endtask

    // scoreboard monitor
    always begin
        @(posedge clk);
        #5;
        cyc++;
        if (rst_n) begin
            for (int d = 0; d < N; d++) begin
                if (out_valid[d]) begin
                    int s;
                    logic [W-1:0] l;
                    s = int'(out_src[d*SW +: SW]);
                    l = out_label[d*W +: W];
                    out_cnt[d]++;
                    if (d == 7) order7.push_back(s);
                    if (d == 9) begin
                        if (first9 < 0) first9 = cyc;
                        last9 = cyc;
                    end
                    if (s >= N || expq[d*N+s].size() == 0) begin
                        chk(1'b0, "R3 unexpected output", d, -1);
                    end else begin
                        logic [W-1:0] e;
                        e = expq[d*N+s].pop_front();
                        chk(l == e, "R5 label order", int'(l), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int tot;
        for (int i = 0; i < N; i++) begin
            men[i] = '0;
            out_cnt[i] = 0;
            drop_exp[i] = 0;
        end
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
        chk(ovf_count == '0, "R1 counters", int'(ovf_count[CW-1:0]), 0);

        // R1: empty matrix, nothing routed
        tick({N{1'b1}}, 1'b0, 0, '0);
        idle(5);
        tot = 0;
        for (int d = 0; d < N; d++) tot += out_cnt[d];
        chk(tot == 0, "R1 no routes", tot, 0);

        // R2 / R3: row 0 to 1,2,5; self bit clear
        tick('0, 1'b1, 0, 12'b0000_0010_0110);
        tick(12'b1, 1'b0, 0, '0);
        @(posedge clk); #6;
        chk(out_valid == '0, "R2 latency early", int'(out_valid), 0);
        tick('0, 1'b0, 0, '0);
        @(posedge clk); #6;
        chk(out_valid == 12'b0000_0010_0110, "R2 broadcast", int'(out_valid), 38);
        idle(4);
        chk(out_cnt[1] == 1 && out_cnt[2] == 1 && out_cnt[5] == 1, "R2 copies", out_cnt[5], 1);
        chk(out_cnt[0] == 0, "R3 self route", out_cnt[0], 0);

        // R6 / R5: fan-in 3:1 onto destination 7
        tick('0, 1'b1, 0, 12'b0000_1000_0000);
        tick('0, 1'b1, 1, 12'b0000_1000_0000);
        tick('0, 1'b1, 2, 12'b0000_1000_0000);
        tick(12'b111, 1'b0, 0, '0);
        tick(12'b111, 1'b0, 0, '0);
        idle(10);
        chk(out_cnt[7] == 6, "R6 fan-in count", out_cnt[7], 6);
        for (int i = 0; i < 6; i++) begin
            int got;
            got = (i < order7.size()) ? order7[i] : -1;
            chk(got == i % 3, "R6 round-robin order", got, i % 3);
        end

        // R8: back-to-back stream from 4 to 9
        tick('0, 1'b1, 4, 12'b0010_0000_0000);
        for (int i = 0; i < 10; i++) tick(12'b1_0000, 1'b0, 0, '0);
        idle(5);
        chk(out_cnt[9] == 10, "R8 stream count", out_cnt[9], 10);
        chk(last9 - first9 == 9, "R8 no gaps", last9 - first9, 9);

        // R4: config write timing on row 5
        tick(12'b10_0000, 1'b1, 5, 12'b0100_0000_0000);
        tick(12'b10_0000, 1'b1, 5, '0);
        tick(12'b10_0000, 1'b0, 0, '0);
        idle(5);
        chk(out_cnt[10] == 1, "R4 write timing", out_cnt[10], 1);

        // R7 / R9: paused destination 3 fills and drops
        tick('0, 1'b1, 6, 12'b0000_0000_1000);
        @(negedge clk);
        pause[3] = 1'b1;
        for (int i = 0; i < 20; i++) tick(12'b100_0000, 1'b0, 0, '0);
        idle(5);
        chk(out_cnt[3] == 0, "R7 paused output", out_cnt[3], 0);
        chk(int'(ovf_count[3*CW +: CW]) == 4, "R9 drop count", int'(ovf_count[3*CW +: CW]), 4);
        chk(drop_exp[3] == 4, "R9 model drops", drop_exp[3], 4);
        @(negedge clk);
        pause[3] = 1'b0;
        idle(25);
        chk(out_cnt[3] == 16, "R7 held spikes", out_cnt[3], 16);
        chk(int'(ovf_count[3*CW +: CW]) == 4, "R9 counter held", int'(ovf_count[3*CW +: CW]), 4);
        chk(ovf_count[2*CW +: CW] == '0, "R9 other port", int'(ovf_count[2*CW +: CW]), 0);

        tot = 0;
        for (int i = 0; i < N*N; i++) tot += expq[i].size();
        chk(tot == 0, "R5 all delivered", tot, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule